// File: doc/BRIEF.md
# Address-Masked GPIO Port Registers

This block holds the control state for a general-purpose pin port of several banks, eight pins each (three banks, 24 pins by default). It sits on a simple byte-wide synchronous register bus. For every bank it keeps three registers: an output value latch, a pin direction register and an alternate-function select register. It drives the pin output values and output enables, and it samples the pin input levels.

Accesses to the data and direction registers take their pin mask from the address. Address bits [9:2] select pins 0..7 of the addressed bank. A write changes only the selected pins, and a read returns only the selected pins. Software can therefore set, clear or test any subset of pins in one bus cycle, with no read-modify-write sequence. The alternate-function bits are exported so that pad logic elsewhere can hand the pin over to another function. While a pin's alternate bit is set, this block withdraws its output enable for that pin.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset all output latches, direction bits and alternate-select bits are 0. As a result pin_out, pin_oe, alt_sel and bus_rdata are all 0.
- R2: Bank n decodes at byte addresses n*0x1000 to n*0x1000+0xFFF. Within a bank, offset bits [11:10]=00 select the data register, [11:10]=10 select the direction register, and the exact offset 0x420 selects the alternate-select register.
- R3: A write to the data register sets the output latch of every pin k whose address bit k+2 is 1 to bit k of bus_wdata. All other latches are unchanged, so an all-zero mask changes nothing.
- R4: A write to the direction register updates only the masked pins in the same way. A direction bit of 1 makes the pin an output; 0 makes it an input.
- R5: A data read returns, in bit k, the driven value if pin k is an output and the sampled pin_in level if it is an input, but only for masked pins. Unmasked bits read 0.
- R6: A direction read returns the masked direction bits. Unmasked bits read 0.
- R7: The alternate-select register of a bank is loaded whole from one byte write and reads back whole. It appears on alt_sel[8n+7:8n].
- R8: pin_oe of each pin equals its direction bit AND NOT its alternate-select bit.
- R9: Writes to unmapped addresses change no state, and reads of them return 0. Unmapped addresses are a bank index of NUM_BANKS or above, offset region [11:10]=11, and region 01 other than 0x420.
- R10: bus_rdata presents the value addressed in a cycle with bus_rd=1 on the clock edge that ends that cycle. Every other cycle leaves it at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 14 | Byte address: bank in [13:12], register offset in [11:0], pin mask in [9:2] |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read request |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 24 | Sampled pin levels |
| pin_out | output | 24 | Pin output values |
| pin_oe | output | 24 | Pin output enables |
| alt_sel | output | 24 | Alternate-function select bits |

## Verification
The hardest case to reach is a data read of a bank whose pins are a mix of inputs and outputs, with the driven value and the pad level disagreeing on every pin. Only then does a read show which source each bit came from. The stimulus first drives latch values with masked writes and then turns half the pins into outputs. It then presents an input pattern that is the opposite of the latches, and it reads through both a full mask and partial masks. Each bit's source and masking can then be checked separately.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
   typedef enum logic [1:0] {
      RG_NONE = 2'd0,
      RG_DATA = 2'd1,
      RG_DIR  = 2'd2,
      RG_ALT  = 2'd3
   } region_e;

   localparam int OFS_W      = 12;
   localparam logic [OFS_W-1:0] ALT_OFS = 12'h420;
   localparam logic [1:0] SEG_DATA = 2'b00;
   localparam logic [1:0] SEG_ALT  = 2'b01;
   localparam logic [1:0] SEG_DIR  = 2'b10;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
   import gpio_mask_pkg::*;
#(
   parameter int ADDR_W     = 14,
   parameter int NUM_BANKS  = 3,
   parameter int BANK_W     = 8,
   parameter int BANK_SEL_W = ADDR_W - OFS_W
) (
   input  logic [ADDR_W-1:0]     addr,
   output region_e               region,
   output logic [BANK_SEL_W-1:0] bank,
   output logic [BANK_W-1:0]     mask
);
   logic [OFS_W-1:0] ofs;
   logic             bank_ok;

   assign ofs     = addr[OFS_W-1:0];
   assign bank    = addr[ADDR_W-1:OFS_W];
   assign bank_ok = (32'(bank) < NUM_BANKS);
   assign mask    = addr[BANK_W+1:2];

   always_comb begin
      region = RG_NONE;
      if (bank_ok) begin
         unique case (ofs[11:10])
            SEG_DATA: region = RG_DATA;
            SEG_DIR:  region = RG_DIR;
            SEG_ALT:  region = (ofs == ALT_OFS) ? RG_ALT : RG_NONE;
            default:  region = RG_NONE;
         endcase
      end
   end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_mask_pkg::*;
#(
   parameter int BANK_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  region_e           region,
   input  logic [BANK_W-1:0] mask,
   input  logic              wr,
   input  logic [BANK_W-1:0] wdata,
   input  logic [BANK_W-1:0] pin_in,
   output logic [BANK_W-1:0] pin_out,
   output logic [BANK_W-1:0] pin_oe,
   output logic [BANK_W-1:0] alt,
   output logic [BANK_W-1:0] rd_val
);
   logic [BANK_W-1:0] out_q, dir_q, alt_q;
   logic              wr_data, wr_dir, wr_alt;
   logic [BANK_W-1:0] level;

   assign wr_data = sel && wr && (region == RG_DATA);
   assign wr_dir  = sel && wr && (region == RG_DIR);
   assign wr_alt  = sel && wr && (region == RG_ALT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_q <= '0;
         dir_q <= '0;
         alt_q <= '0;
      end else begin
         if (wr_data) out_q <= (out_q & ~mask) | (wdata & mask);
         if (wr_dir)  dir_q <= (dir_q & ~mask) | (wdata & mask);
         if (wr_alt)  alt_q <= wdata;
      end
   end

   genvar k;
   generate
      for (k = 0; k < BANK_W; k++) begin : g_pin
         assign level[k]  = dir_q[k] ? out_q[k] : pin_in[k];
         assign pin_oe[k] = dir_q[k] & ~alt_q[k];
      end
   endgenerate

   always_comb begin
      rd_val = '0;
      if (sel) begin
         unique case (region)
            RG_DATA: rd_val = level & mask;
            RG_DIR:  rd_val = dir_q & mask;
            RG_ALT:  rd_val = alt_q;
            default: rd_val = '0;
         endcase
      end
   end

   assign pin_out = out_q;
   assign alt     = alt_q;
endmodule

// File: rtl/gpio_read_port.sv
module gpio_read_port #(
   parameter int NUM_BANKS = 3,
   parameter int BANK_W    = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             rd,
   input  logic [NUM_BANKS-1:0][BANK_W-1:0] bank_vals,
   output logic [BANK_W-1:0]                rdata
);
   logic [BANK_W-1:0] merged;

   always_comb begin
      merged = '0;
      for (int b = 0; b < NUM_BANKS; b++) merged |= bank_vals[b];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  rdata <= '0;
      else if (rd) rdata <= merged;
      else         rdata <= '0;
   end
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
   import gpio_mask_pkg::*;
#(
   parameter int NUM_BANKS = 3,
   parameter int BANK_W    = 8,
   parameter int ADDR_W    = 14,
   localparam int PINS       = NUM_BANKS * BANK_W,
   localparam int BANK_SEL_W = ADDR_W - OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [BANK_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [BANK_W-1:0] bus_rdata,
   input  logic [PINS-1:0]   pin_in,
   output logic [PINS-1:0]   pin_out,
   output logic [PINS-1:0]   pin_oe,
   output logic [PINS-1:0]   alt_sel
);
   generate
      if (BANK_W < 1 || BANK_W > 8) begin : g_bad_w
         $error("BANK_W must be 1..8 so the mask fits in address bits [9:2]");
      end
      if (NUM_BANKS < 1) begin : g_bad_n
         $error("NUM_BANKS must be at least 1");
      end
      if (BANK_SEL_W < 1 || (1 << BANK_SEL_W) < NUM_BANKS) begin : g_bad_a
         $error("ADDR_W too small for NUM_BANKS windows of 4 KiB");
      end
   endgenerate

   region_e                          region;
   logic [BANK_SEL_W-1:0]            bank;
   logic [BANK_W-1:0]                mask;
   logic [NUM_BANKS-1:0][BANK_W-1:0] bank_vals;

   gpio_addr_decode #(
      .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS),
      .BANK_W(BANK_W), .BANK_SEL_W(BANK_SEL_W)
   ) u_dec (
      .addr(bus_addr), .region(region), .bank(bank), .mask(mask)
   );

   genvar b;
   generate
      for (b = 0; b < NUM_BANKS; b++) begin : g_bank
         logic sel;
         assign sel = (bank == BANK_SEL_W'(b));
         gpio_bank #(.BANK_W(BANK_W)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .sel    (sel),
            .region (region),
            .mask   (mask),
            .wr     (bus_wr),
            .wdata  (bus_wdata),
            .pin_in (pin_in [b*BANK_W +: BANK_W]),
            .pin_out(pin_out[b*BANK_W +: BANK_W]),
            .pin_oe (pin_oe [b*BANK_W +: BANK_W]),
            .alt    (alt_sel[b*BANK_W +: BANK_W]),
            .rd_val (bank_vals[b])
         );
      end
   endgenerate

   gpio_read_port #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd(bus_rd),
      .bank_vals(bank_vals), .rdata(bus_rdata)
   );
endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
   parameter int NUM_BANKS = 3,
   parameter int BANK_W    = 8,
   parameter int ADDR_W    = 14,
   localparam int PINS     = NUM_BANKS * BANK_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [BANK_W-1:0] bus_rdata,
   input logic [PINS-1:0]   pin_out,
   input logic [PINS-1:0]   pin_oe,
   input logic [PINS-1:0]   alt_sel
);
   logic [PINS-1:0] data_wmask;
   logic [PINS-1:0] alt_wmask;
   int              bidx;

   always_comb begin
      data_wmask = '0;
      alt_wmask  = '0;
      bidx       = 32'(bus_addr[ADDR_W-1:12]);
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (bidx == b && bus_wr) begin
            if (bus_addr[11:10] == 2'b00)
               data_wmask[b*BANK_W +: BANK_W] = bus_addr[BANK_W+1:2];
            if (bus_addr[11:0] == 12'h420)
               alt_wmask[b*BANK_W +: BANK_W] = '1;
         end
      end
   end

   // R3: only masked data pins of the addressed bank may change
   assert_masked_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((pin_out ^ $past(pin_out)) & ~$past(data_wmask)) == '0));

   // R7: alternate bits change only on a write to the alternate offset
   assert_alt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((alt_sel ^ $past(alt_sel)) & ~$past(alt_wmask)) == '0));

   // R8: an alternate-owned pin is never driven
   assert_alt_blocks_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe & alt_sel) == '0);

   // R10: no read request, no read data
   assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> (bus_rdata == '0));

   // R1: outputs are zero right after reset
   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (pin_out == '0 && pin_oe == '0 && alt_sel == '0 && bus_rdata == '0));
endmodule

bind gpio_mask_port gpio_mask_port_chk #(
   .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_rd(bus_rd), .bus_rdata(bus_rdata), .pin_out(pin_out),
   .pin_oe(pin_oe), .alt_sel(alt_sel)
);

// File: tb/tb_gpio_mask_port.sv
module tb_gpio_mask_port;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [13:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_rdata;
   logic [23:0] pin_in = '0;
   logic [23:0] pin_out, pin_oe, alt_sel;

   int n_run = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_mask_port dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .alt_sel(alt_sel)
   );

   task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [13:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [13:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   function automatic logic [13:0] data_a(input int bank, input logic [7:0] m);
      return 14'(bank * 14'h1000) | {4'h0, m, 2'b00};
   endfunction

   function automatic logic [13:0] dir_a(input int bank, input logic [7:0] m);
      return data_a(bank, m) | 14'h0800;
   endfunction

   task automatic t_reset();
      check("R1 pin_out", pin_out, 24'h0);
      check("R1 pin_oe", pin_oe, 24'h0);
      check("R1 alt_sel", alt_sel, 24'h0);
      check("R1 rdata", {16'h0, bus_rdata}, 24'h0);
   endtask

   task automatic t_data_mask();
      bus_write(data_a(0, 8'h05), 8'hFF);
      check("R3 set masked", pin_out, 24'h000005);
      bus_write(data_a(0, 8'h01), 8'h00);
      check("R3 clear one", pin_out, 24'h000004);
      bus_write(data_a(0, 8'h00), 8'hFF);
      check("R3 empty mask", pin_out, 24'h000004);
      bus_write(data_a(1, 8'hF0), 8'hAA);
      check("R2 R3 bank1", pin_out, 24'h00A004);
   endtask

   task automatic t_dir();
      logic [7:0] r;
      bus_write(dir_a(0, 8'h0F), 8'hFF);
      check("R4 dir out", pin_oe, 24'h00000F);
      bus_write(dir_a(0, 8'h03), 8'h00);
      check("R4 dir in", pin_oe, 24'h00000C);
      bus_write(dir_a(0, 8'h03), 8'hFF);
      bus_read(dir_a(0, 8'hFF), r);
      check("R6 dir full", {16'h0, r}, 24'h0F);
      bus_read(dir_a(0, 8'h30), r);
      check("R6 dir unmasked", {16'h0, r}, 24'h00);
      bus_read(dir_a(0, 8'h06), r);
      check("R6 dir partial", {16'h0, r}, 24'h06);
   endtask

   task automatic t_data_read();
      logic [7:0] r;
      pin_in = 24'h0000FB;
      bus_read(data_a(0, 8'hFF), r);
      check("R5 mixed full", {16'h0, r}, 24'hF4);
      bus_read(data_a(0, 8'h14), r);
      check("R5 mixed partial", {16'h0, r}, 24'h14);
      bus_read(data_a(0, 8'h08), r);
      check("R5 output low", {16'h0, r}, 24'h00);
      pin_in = 24'h5A0000;
      bus_read(data_a(2, 8'hFF), r);
      check("R5 R2 bank2 inputs", {16'h0, r}, 24'h5A);
   endtask

   task automatic t_alt();
      logic [7:0] r;
      bus_write(14'h2420, 8'h81);
      check("R7 alt bank2", alt_sel, 24'h810000);
      bus_read(14'h2420, r);
      check("R7 alt read", {16'h0, r}, 24'h81);
      bus_write(14'h0420, 8'h02);
      check("R8 oe gated", pin_oe, 24'h00000D);
      check("R8 out kept", pin_out, 24'h00A004);
      bus_write(14'h0420, 8'h00);
      check("R8 oe restored", pin_oe, 24'h00000F);
   endtask

   task automatic t_unmapped();
      logic [7:0] r;
      bus_write(14'h33FC, 8'hFF);
      bus_write(14'h0C3C, 8'hFF);
      bus_write(14'h0424, 8'hFF);
      check("R9 out", pin_out, 24'h00A004);
      check("R9 oe", pin_oe, 24'h00000F);
      check("R9 alt", alt_sel, 24'h810000);
      bus_read(14'h33FC, r);
      check("R9 read bank3", {16'h0, r}, 24'h0);
      bus_read(14'h0C3C, r);
      check("R9 read seg11", {16'h0, r}, 24'h0);
      bus_read(14'h0424, r);
      check("R9 read near alt", {16'h0, r}, 24'h0);
   endtask

   task automatic t_timing();
      @(negedge clk);
      bus_addr = dir_a(0, 8'hFF); bus_rd = 1'b1;
      #1 check("R10 not before edge", {16'h0, bus_rdata}, 24'h0);
      @(negedge clk);
      bus_rd = 1'b0;
      check("R10 after edge", {16'h0, bus_rdata}, 24'h0F);
      @(negedge clk);
      check("R10 idle zero", {16'h0, bus_rdata}, 24'h0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_data_mask();
      t_dir();
      t_data_read();
      t_alt();
      t_unmapped();
      t_timing();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      t_reset();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule